// File: doc/BRIEF.md
# Splittable Lookup-Table Logic Cell

This block is a configurable logic cell built around one 32-entry, one-bit-wide truth table held in configuration registers. Five logic inputs and two cell-local flip-flops feed the table. In whole-table mode the five inputs address all 32 entries, and both combinational results carry the same five-input function. In split mode the table becomes two independent 16-entry halves. Each half gives a four-input function whose fourth input is picked per half from the two upper logic inputs or from either flip-flop. This lets the cell build small state machines around its own registers.

Two flip-flops share the clock and a clock enable. They capture the two combinational results. Each cell output is steered on its own, by configuration, to either the combinational result or the matching flip-flop. A result is one table read after its inputs, whatever function is loaded.

Configuration goes through a narrow write port with an address and a data word. It is expected to be quiet while the cell does its normal work. The cell has no streaming interface: the logic inputs, outputs and configuration port are plain level signals with no back-pressure.

Top module: `clb_split_lut`

## Requirements
- R1: After reset the table, the control word and both flip-flops are zero, so all four outputs read 0 for any input.
- R2: With the split bit clear, output f_out equals table entry {lin[4],lin[3],lin[2],lin[1],lin[0]}, with lin[0] as the address LSB. Loading only entry 31 gives a five-input AND.
- R3: With the split bit clear, g_out always equals f_out.
- R4: With the split bit set, f_out reads table bits 15..0 at index {pick_f,lin[2],lin[1],lin[0]}. g_out reads table bits 31..16 at index {pick_g,lin[2],lin[1],lin[0]}. The picked signal is index bit 3.
- R5: Each 2-bit pick field selects the fourth input by this code: 0 picks lin[3], 1 picks lin[4], 2 picks flip-flop qx, 3 picks flip-flop qy.
- R6: On a rising clock edge with ce high, qx loads f_out and qy loads g_out. With ce low both hold.
- R7: x_out shows f_out when control bit 5 is 0 and qx when it is 1. y_out shows g_out when control bit 6 is 0 and qy when it is 1.
- R8: A write with cfg_we high at a rising edge stores cfg_wdata. Address 0 writes the whole table. Address 1 writes the control word: bit 0 split, bits 2..1 pick_f, bits 4..3 pick_g, bit 5 x registered, bit 6 y registered. The new value governs outputs from just after that edge.
- R9: A write to address 2 or 3 changes no output: the table and control word are unchanged.
- R10: f_out, g_out and any output on its combinational path change in the same cycle as lin. The only register on the path is the configuration storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for flip-flops and configuration |
| rst_n | input | 1 | Asynchronous active-low reset |
| lin | input | 5 | Logic inputs, bit 0 is the lowest table address bit |
| ce | input | 1 | Clock enable of both flip-flops |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| f_out | output | 1 | First combinational result |
| g_out | output | 1 | Second combinational result |
| x_out | output | 1 | First steered output |
| y_out | output | 1 | Second steered output |

## Verification
The combinational results f_out and g_out, and x_out or y_out when steered to them, are due in the same cycle as a change on lin. The bench drives inputs on the falling edge and compares a few nanoseconds later, before the next rising edge. Flip-flop values appear one rising edge after a cycle with ce high. The bench's own model updates its copies of qx and qy at that same edge, using the values it has just checked. A configuration write takes effect at the edge that samples it. The first comparison against the new setting comes at the following falling edge.

// File: rtl/clb_split_pkg.sv
package clb_split_pkg;
  localparam int LUT_IN    = 5;
  localparam int LUT_BITS  = 1 << LUT_IN;
  localparam int HALF_IN   = LUT_IN - 1;
  localparam int SHARED_IN = HALF_IN - 1;

  typedef enum logic [1:0] {
    PICK_IN3 = 2'd0,
    PICK_IN4 = 2'd1,
    PICK_QX  = 2'd2,
    PICK_QY  = 2'd3
  } pick_e;

  // packed MSB first: y_reg is bit 6, split is bit 0
  typedef struct packed {
    logic  y_reg;
    logic  x_reg;
    pick_e g_pick;
    pick_e f_pick;
    logic  split;
  } clb_ctrl_t;

  localparam int CTRL_W = $bits(clb_ctrl_t);
endpackage

// File: rtl/clb_cfg_regs.sv
module clb_cfg_regs
  import clb_split_pkg::*;
#(
  parameter int CFG_AW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [LUT_BITS-1:0] cfg_wdata,
  output logic [LUT_BITS-1:0] table_q,
  output clb_ctrl_t           ctrl_q
);
  localparam logic [CFG_AW-1:0] TABLE_ADDR = CFG_AW'(0);
  localparam logic [CFG_AW-1:0] CTRL_ADDR  = CFG_AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      table_q <= '0;
      ctrl_q  <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == TABLE_ADDR) table_q <= cfg_wdata;
      if (cfg_addr == CTRL_ADDR)  ctrl_q  <= clb_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
    end
  end
endmodule

// File: rtl/clb_lut_read.sv
module clb_lut_read
  import clb_split_pkg::*;
(
  input  logic [LUT_BITS-1:0] table_q,
  input  clb_ctrl_t           ctrl_q,
  input  logic [LUT_IN-1:0]   lin,
  input  logic                q_x,
  input  logic                q_y,
  output logic                f_out,
  output logic                g_out
);
  logic [HALF_IN-1:0] f_idx, g_idx;

  function automatic logic pick_src(pick_e sel, logic [LUT_IN-1:0] v,
                                    logic qa, logic qb);
    case (sel)
      PICK_IN3: return v[3];
      PICK_IN4: return v[4];
      PICK_QX:  return qa;
      default:  return qb;
    endcase
  endfunction

  always_comb begin
    f_idx = {pick_src(ctrl_q.f_pick, lin, q_x, q_y), lin[SHARED_IN-1:0]};
    g_idx = {pick_src(ctrl_q.g_pick, lin, q_x, q_y), lin[SHARED_IN-1:0]};
    if (ctrl_q.split) begin
      f_out = table_q[{1'b0, f_idx}];
      g_out = table_q[{1'b1, g_idx}];
    end else begin
      f_out = table_q[lin];
      g_out = table_q[lin];
    end
  end
endmodule

// File: rtl/clb_out_stage.sv
module clb_out_stage #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [LANES-1:0] comb_in,
  input  logic [LANES-1:0] reg_sel,
  output logic [LANES-1:0] q_out,
  output logic [LANES-1:0] pin_out
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q_out[i] <= 1'b0;
      else if (ce) q_out[i] <= comb_in[i];
    end
    assign pin_out[i] = reg_sel[i] ? q_out[i] : comb_in[i];
  end
endmodule

// File: rtl/clb_split_lut.sv
module clb_split_lut
  import clb_split_pkg::*;
#(
  parameter int CFG_AW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LUT_IN-1:0]   lin,
  input  logic                ce,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [LUT_BITS-1:0] cfg_wdata,
  output logic                f_out,
  output logic                g_out,
  output logic                x_out,
  output logic                y_out
);
  logic [LUT_BITS-1:0] table_q;
  clb_ctrl_t           ctrl_q;
  logic                q_x, q_y;
  logic [1:0]          q_vec, pin_vec;

  clb_cfg_regs #(.CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .table_q(table_q), .ctrl_q(ctrl_q)
  );

  clb_lut_read u_read (
    .table_q(table_q), .ctrl_q(ctrl_q), .lin(lin), .q_x(q_x), .q_y(q_y),
    .f_out(f_out), .g_out(g_out)
  );

  clb_out_stage #(.LANES(2)) u_out (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .comb_in({g_out, f_out}),
    .reg_sel({ctrl_q.y_reg, ctrl_q.x_reg}),
    .q_out(q_vec), .pin_out(pin_vec)
  );

  assign q_x   = q_vec[0];
  assign q_y   = q_vec[1];
  assign x_out = pin_vec[0];
  assign y_out = pin_vec[1];
endmodule

// File: rtl/clb_split_lut_chk.sv
module clb_split_lut_chk
  import clb_split_pkg::*;
#(
  parameter int CFG_AW = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ce,
  input logic                cfg_we,
  input logic [CFG_AW-1:0]   cfg_addr,
  input logic [LUT_BITS-1:0] cfg_wdata,
  input logic                f_out,
  input logic                g_out,
  input logic                x_out,
  input logic [LUT_BITS-1:0] table_q,
  input clb_ctrl_t           ctrl_q,
  input logic                q_x
);
  // R6
  ff_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce |=> (q_x == $past(f_out)));

  // R6
  ff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |=> $stable(q_x));

  // R3
  whole_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.split |-> (f_out == g_out));

  // R4
  low_half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.split && table_q[LUT_BITS/2-1:0] == '0) |-> !f_out);

  // R7
  x_reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.x_reg && !ce && !cfg_we) |=> $stable(x_out));

  // R8
  table_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CFG_AW'(0)) |=> (table_q == $past(cfg_wdata)));

  // R8
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CFG_AW'(1)) |=> (ctrl_q == $past(cfg_wdata[CTRL_W-1:0])));

  // R9
  unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr > CFG_AW'(1)) |=> ($stable(table_q) && $stable(ctrl_q)));
endmodule

bind clb_split_lut clb_split_lut_chk #(.CFG_AW(CFG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce(ce), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .f_out(f_out), .g_out(g_out), .x_out(x_out),
  .table_q(table_q), .ctrl_q(ctrl_q), .q_x(q_x)
);

// File: tb/clb_split_lut_test.sv
module clb_split_lut_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  lin = '0;
  logic        ce = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        f_out, g_out, x_out, y_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model state
  logic [31:0] m_tab = '0;
  logic [6:0]  m_ctl = '0;
  logic        m_qx = 1'b0, m_qy = 1'b0;

  always #10 clk = ~clk;

  clb_split_lut uut (
    .clk(clk), .rst_n(rst_n), .lin(lin), .ce(ce), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .f_out(f_out),
    .g_out(g_out), .x_out(x_out), .y_out(y_out)
  );

  task automatic check(string tag, logic got, logic exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%b exp=%b lin=%h ctl=%h", tag, got, exp, lin, m_ctl);
    end
  endtask

  function automatic logic pick_bit(logic [1:0] sel, logic [4:0] v);
    case (sel)
      2'd0: return v[3];
      2'd1: return v[4];
      2'd2: return m_qx;
      default: return m_qy;
    endcase
  endfunction

  function automatic logic [1:0] model_fg(logic [4:0] v);
    logic [4:0] fi, gi;
    if (m_ctl[0]) begin
      fi = {1'b0, pick_bit(m_ctl[2:1], v), v[2:0]};
      gi = {1'b1, pick_bit(m_ctl[4:3], v), v[2:0]};
      return {m_tab[gi], m_tab[fi]};
    end
    return {m_tab[v], m_tab[v]};
  endfunction

  task automatic cfg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    ce = 1'b0; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    #1 cfg_we = 1'b0;
    if (a == 2'd0) m_tab = d;
    if (a == 2'd1) m_ctl = d[6:0];
  endtask

  // drive at falling edge, compare before rising edge, then update model flops
  task automatic step(logic [4:0] v, logic ce_v, string tag);
    logic [1:0] e;
    @(negedge clk);
    lin = v; ce = ce_v;
    #5;
    e = model_fg(v);
    check({tag, " f"}, f_out, e[0]);
    check({tag, " g"}, g_out, e[1]);
    check({tag, " x R7"}, x_out, m_ctl[5] ? m_qx : e[0]);
    check({tag, " y R7"}, y_out, m_ctl[6] ? m_qy : e[1]);
    @(posedge clk);
    if (ce_v) begin m_qx = e[0]; m_qy = e[1]; end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    lin = 5'h1f;
    #5;
    // R1: all cleared after reset
    check("R1 f", f_out, 1'b0);
    check("R1 g", g_out, 1'b0);
    check("R1 x", x_out, 1'b0);
    check("R1 y", y_out, 1'b0);

    // R2 five-input AND, R8 table write
    cfg_write(2'd0, 32'h8000_0000);
    for (int i = 0; i < 32; i++) step(5'(i), 1'b0, "R2 R3 R8 R10 and5");

    cfg_write(2'd0, 32'h6996_A53C);
    for (int i = 0; i < 32; i++) step(5'(i), 1'b0, "R2 R3 pattern");

    // R4 R5 split, every pick pair, flops running
    cfg_write(2'd0, 32'h5A3C_C3E1);
    for (int fp = 0; fp < 4; fp++)
      for (int gp = 0; gp < 4; gp++) begin
        cfg_write(2'd1, {25'd0, 2'(gp), 2'(fp), 1'b1});
        for (int i = 0; i < 32; i++) step(5'(i * 7 + fp), 1'b1, "R4 R5 R6");
      end

    // R6 R7 registered outputs, ce toggling
    cfg_write(2'd1, {25'd0, 1'b1, 1'b1, 2'd3, 2'd2, 1'b1});
    for (int i = 0; i < 64; i++) step(5'(i * 3), 1'(i % 3 != 0), "R6 R7");

    // whole mode with registered outputs
    cfg_write(2'd1, 32'h0000_0060);
    for (int i = 0; i < 32; i++) step(5'(31 - i), 1'(i % 2), "R6 R7 whole");

    // R9 writes to unused addresses change nothing
    cfg_write(2'd2, 32'hFFFF_FFFF);
    cfg_write(2'd3, 32'h0000_0001);
    for (int i = 0; i < 32; i++) step(5'(i), 1'b0, "R9");

    // feedback toggle: low half = NOT of picked qx
    cfg_write(2'd0, 32'h00FF_00FF);
    cfg_write(2'd1, {25'd0, 1'b0, 1'b1, 2'd2, 2'd2, 1'b1});
    for (int i = 0; i < 16; i++) step(5'(i % 8), 1'b1, "R5 R6 toggle");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule